// File: doc/BRIEF.md
# Write-Allocate Qualification Unit

This unit decides, for every pending memory write, whether the cache may perform a write allocate. It holds one small control register, written and read through a simple register port and cleared by reset. The register carries a 7-bit upper limit counted in 4-Mbyte steps and an enable bit for the 1-Mbyte window that lies just below 16 Mbytes.

Each write presents a 32-bit physical address with a valid strobe and two flags from neighbouring logic: a cacheable-page hit and a sector hit. The limit rule grants allocation only below the programmed limit. Inside that range it still refuses the legacy hole between 640 Kbytes and 1 Mbyte, and it refuses the 15–16 Mbyte window unless that window is enabled. Either hit flag grants allocation regardless of the limit rule. The verdict is registered and appears one cycle after the strobe, together with a valid output.

Top module: `wa_qual_unit`

## Requirements
- R1: After reset the register reads 0, alloc_valid_o is 0 and alloc_o is 0.
- R2: Register bit 0 is the window enable and bits 7:1 are the limit field. Bits 31:8 always read 0, and writes to them are ignored.
- R3: With both hit flags low, a write outside the hole and the window is allocated exactly when its address is below the limit field times 0x0040_0000.
- R4: When the limit field is 0, a write with both hit flags low is never allocated.
- R5: When the limit field is 4 or more, a write to 0x00F0_0000–0x00FF_FFFF with both hit flags low is allocated only if the window enable bit is 1.
- R6: When the limit field is below 4, the window enable bit does not change any decision.
- R7: A write to 0x000A_0000–0x000F_FFFF with both hit flags low is never allocated.
- R8: A write with page_hit_i or sector_hit_i set is always allocated.
- R9: The cycle after wr_valid_i is high, alloc_valid_o is 1 and carries the decision. The cycle after wr_valid_i is low, both alloc_valid_o and alloc_o are 0.
- R10: A pending write in the same cycle as a register write is judged with the register value from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| wr_valid_i | input | 1 | Pending write strobe |
| wr_addr_i | input | 32 | Physical address of the pending write |
| page_hit_i | input | 1 | Cacheable-page mechanism grants allocation |
| sector_hit_i | input | 1 | Sector mechanism grants allocation |
| alloc_valid_o | output | 1 | Decision valid, one cycle after the strobe |
| alloc_o | output | 1 | Write allocate granted |

## Verification
The bench builds the unit with its default parameters: a 32-bit address, a 7-bit limit field and a 4-Mbyte granule. With these values the full limit space of 128 values can be swept with both settings of the window enable bit. For each setting, the bench probes the addresses just below and at the limit, both edges of the legacy hole, both edges of the window, and the address extremes. Each probe is run under all four combinations of the hit flags. Expected verdicts come from plain byte arithmetic in the bench, which reaches every limit-versus-window interaction, including the values of the limit field below 4 where the enable bit must have no effect.

// File: rtl/wa_qual_pkg.sv
package wa_qual_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned LIM_W      = 7;
  localparam int unsigned LIM_LSB    = 1;
  localparam int unsigned WIN_EN_BIT = 0;
  localparam int unsigned GRAN_SHIFT = 22;  // 4 Mbyte granule
  localparam int unsigned MB_SHIFT   = 20;
  localparam int unsigned WIN_MB     = 15;  // window is [WIN_MB, WIN_MB+1) Mbyte
  localparam logic [31:0] HOLE_LO    = 32'h000A_0000;
  localparam logic [31:0] HOLE_END   = 32'h0010_0000;

  typedef struct packed {
    logic [LIM_W-1:0] lim;
    logic             win_en;
  } wa_ctl_t;

  typedef struct packed {
    logic below;
    logic in_hole;
    logic in_win;
  } wa_region_t;
endpackage

// File: rtl/wa_ctl_reg.sv
module wa_ctl_reg
  import wa_qual_pkg::*;
#(
  parameter int unsigned DATA_W_P = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W_P-1:0] wdata_i,
  output logic [DATA_W_P-1:0] rdata_o,
  output wa_ctl_t           ctl_o
);
  localparam int unsigned CTL_W = $bits(wa_ctl_t);

  wa_ctl_t ctl_q;
  logic    unused_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (we_i) begin
      ctl_q.lim    <= wdata_i[LIM_LSB +: LIM_W];
      ctl_q.win_en <= wdata_i[WIN_EN_BIT];
    end
  end

  // reserved and upper bits are not stored
  assign unused_wdata = ^wdata_i[DATA_W_P-1:CTL_W];
  assign rdata_o      = DATA_W_P'(ctl_q);
  assign ctl_o        = ctl_q;
endmodule

// File: rtl/wa_region_dec.sv
module wa_region_dec
  import wa_qual_pkg::*;
#(
  parameter int unsigned ADDR_W_P = ADDR_W,
  parameter int unsigned GRAN_P   = GRAN_SHIFT
) (
  input  logic [ADDR_W_P-1:0] addr_i,
  input  logic [LIM_W-1:0]    lim_i,
  output wa_region_t          region_o
);
  localparam int unsigned HI_W  = ADDR_W_P - GRAN_P;
  localparam int unsigned CMP_W = (HI_W > LIM_W) ? HI_W : LIM_W;
  localparam int unsigned MB_W  = ADDR_W_P - MB_SHIFT;

  logic [CMP_W-1:0] addr_hi;
  logic [CMP_W-1:0] lim_ext;

  // addr < lim * granule  <=>  addr[top:gran] < lim
  assign addr_hi = CMP_W'(addr_i[ADDR_W_P-1:GRAN_P]);
  assign lim_ext = CMP_W'(lim_i);

  always_comb begin
    region_o.below   = addr_hi < lim_ext;
    region_o.in_hole = (addr_i >= ADDR_W_P'(HOLE_LO)) && (addr_i < ADDR_W_P'(HOLE_END));
    region_o.in_win  = addr_i[ADDR_W_P-1:MB_SHIFT] == MB_W'(WIN_MB);
  end
endmodule

// File: rtl/wa_decide.sv
module wa_decide
  import wa_qual_pkg::*;
#(
  parameter int unsigned GRAN_P = GRAN_SHIFT
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_valid_i,
  input  logic       page_hit_i,
  input  logic       sector_hit_i,
  input  wa_ctl_t    ctl_i,
  input  wa_region_t region_i,
  output logic       alloc_valid_o,
  output logic       alloc_o
);
  // smallest limit field value whose range reaches the top of the window
  localparam int unsigned WIN_LIM_MIN = ((WIN_MB + 1) << MB_SHIFT) >> GRAN_P;

  logic lim_covers_win;
  logic win_block;
  logic lim_grant;
  logic alloc_d;

  always_comb begin
    lim_covers_win = ctl_i.lim >= LIM_W'(WIN_LIM_MIN);
    win_block      = region_i.in_win && !ctl_i.win_en && lim_covers_win;
    lim_grant      = region_i.below && !region_i.in_hole && !win_block;
    alloc_d        = page_hit_i || sector_hit_i || lim_grant;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alloc_valid_o <= 1'b0;
      alloc_o       <= 1'b0;
    end else begin
      alloc_valid_o <= wr_valid_i;
      alloc_o       <= wr_valid_i && alloc_d;
    end
  end
endmodule

// File: rtl/wa_qual_unit.sv
module wa_qual_unit
  import wa_qual_pkg::*;
#(
  parameter int unsigned ADDR_W_P = ADDR_W,
  parameter int unsigned DATA_W_P = DATA_W,
  parameter int unsigned GRAN_P   = GRAN_SHIFT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [DATA_W_P-1:0] reg_wdata_i,
  output logic [DATA_W_P-1:0] reg_rdata_o,
  input  logic                wr_valid_i,
  input  logic [ADDR_W_P-1:0] wr_addr_i,
  input  logic                page_hit_i,
  input  logic                sector_hit_i,
  output logic                alloc_valid_o,
  output logic                alloc_o
);
  wa_ctl_t    ctl;
  wa_region_t region;

  wa_ctl_reg #(.DATA_W_P(DATA_W_P)) u_ctl_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .ctl_o   (ctl)
  );

  wa_region_dec #(.ADDR_W_P(ADDR_W_P), .GRAN_P(GRAN_P)) u_region_dec (
    .addr_i   (wr_addr_i),
    .lim_i    (ctl.lim),
    .region_o (region)
  );

  wa_decide #(.GRAN_P(GRAN_P)) u_decide (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_valid_i    (wr_valid_i),
    .page_hit_i    (page_hit_i),
    .sector_hit_i  (sector_hit_i),
    .ctl_i         (ctl),
    .region_i      (region),
    .alloc_valid_o (alloc_valid_o),
    .alloc_o       (alloc_o)
  );
endmodule

// File: rtl/wa_qual_checker.sv
module wa_qual_checker
  import wa_qual_pkg::*;
#(
  parameter int unsigned ADDR_W_P = ADDR_W,
  parameter int unsigned DATA_W_P = DATA_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                reg_we_i,
  input logic [DATA_W_P-1:0] reg_wdata_i,
  input logic [DATA_W_P-1:0] reg_rdata_o,
  input logic                wr_valid_i,
  input logic [ADDR_W_P-1:0] wr_addr_i,
  input logic                page_hit_i,
  input logic                sector_hit_i,
  input logic                alloc_valid_o,
  input logic                alloc_o
);
  logic hit;
  logic in_hole;
  assign hit     = page_hit_i || sector_hit_i;
  assign in_hole = (wr_addr_i >= ADDR_W_P'(HOLE_LO)) && (wr_addr_i < ADDR_W_P'(HOLE_END));

  p_valid_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> alloc_valid_o);
  p_idle_no_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> (!alloc_valid_o && !alloc_o));
  p_hit_grants_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && hit) |=> alloc_o);
  p_hole_denied_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !hit && in_hole) |=> !alloc_o);
  p_zero_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !hit && reg_rdata_o[LIM_LSB +: LIM_W] == '0) |=> !alloc_o);
  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[DATA_W_P-1:8] == '0);
  p_reg_update_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_rdata_o[7:0] == $past(reg_wdata_i[7:0]));
endmodule

bind wa_qual_unit wa_qual_checker #(.ADDR_W_P(ADDR_W_P), .DATA_W_P(DATA_W_P)) u_wa_qual_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_we_i      (reg_we_i),
  .reg_wdata_i   (reg_wdata_i),
  .reg_rdata_o   (reg_rdata_o),
  .wr_valid_i    (wr_valid_i),
  .wr_addr_i     (wr_addr_i),
  .page_hit_i    (page_hit_i),
  .sector_hit_i  (sector_hit_i),
  .alloc_valid_o (alloc_valid_o),
  .alloc_o       (alloc_o)
);

// File: tb/wa_qual_unit_bench.sv
module wa_qual_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam longint MB = 64'd1048576;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        wr_valid_i = 1'b0;
  logic [31:0] wr_addr_i = '0;
  logic        page_hit_i = 1'b0;
  logic        sector_hit_i = 1'b0;
  logic        alloc_valid_o;
  logic        alloc_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wa_qual_unit u_wa_qual_unit (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i),
    .page_hit_i(page_hit_i), .sector_hit_i(sector_hit_i),
    .alloc_valid_o(alloc_valid_o), .alloc_o(alloc_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  // expected verdict from byte arithmetic
  function automatic bit model(input int lim, input bit en, input logic [31:0] a,
                               input bit ph, input bit sh);
    longint ad = longint'(a);
    bit below = ad < longint'(lim) * 4 * MB;
    bit hole  = ad >= 64'h000A_0000 && ad < 64'h0010_0000;
    bit win   = ad >= 15 * MB && ad < 16 * MB;
    return ph || sh || (below && !hole && !(win && !en && lim >= 4));
  endfunction

  function automatic string rule(input int lim, input logic [31:0] a, input bit ph, input bit sh);
    if (ph || sh) return "R8";
    if (a >= 32'h000A_0000 && a < 32'h0010_0000) return "R7";
    if (lim == 0) return "R4";
    if (a[31:20] == 12'd15) return (lim < 4) ? "R6" : "R5";
    return "R3";
  endfunction

  task automatic probe(input int lim, input bit en, input logic [31:0] a,
                       input bit ph, input bit sh);
    @(negedge clk);
    wr_valid_i = 1'b1; wr_addr_i = a; page_hit_i = ph; sector_hit_i = sh;
    @(negedge clk);
    wr_valid_i = 1'b0; page_hit_i = 1'b0; sector_hit_i = 1'b0;
    check("R9 valid", alloc_valid_o, 1);
    check(rule(lim, a, ph, sh), alloc_o, model(lim, en, a, ph, sh));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] addrs [12];
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdata", reg_rdata_o, 0);
    check("R1 valid", alloc_valid_o, 0);
    check("R1 alloc", alloc_o, 0);
    rst_ni = 1'b1;

    // R2 layout and reserved bits
    reg_write(32'hFFFF_FFFF);
    check("R2 all ones", reg_rdata_o, 32'h0000_00FF);
    reg_write(32'hFFFF_FF00);
    check("R2 upper ignored", reg_rdata_o, 0);
    reg_write(32'h0000_0003);
    check("R2 field", reg_rdata_o, 3);

    // R10 same-cycle register write uses old value (limit 1, en 1)
    @(negedge clk);
    reg_we_i = 1'b1; reg_wdata_i = 32'h0000_0000;
    wr_valid_i = 1'b1; wr_addr_i = 32'h0000_1000;
    @(negedge clk);
    reg_we_i = 1'b0; wr_valid_i = 1'b0;
    check("R10 old value", alloc_o, 1);
    @(negedge clk);
    check("R9 idle valid", alloc_valid_o, 0);
    check("R9 idle alloc", alloc_o, 0);
    probe(0, 1'b0, 32'h0000_1000, 1'b0, 1'b0);

    for (int lim = 0; lim < 128; lim++) begin
      for (int en = 0; en < 2; en++) begin
        reg_write(32'((lim << 1) | en));
        check("R2 readback", reg_rdata_o, (lim << 1) | en);
        addrs[0]  = 32'(longint'(lim) * 4 * MB - 1);
        addrs[1]  = 32'(longint'(lim) * 4 * MB);
        addrs[2]  = 32'h0009_FFFF;
        addrs[3]  = 32'h000A_0000;
        addrs[4]  = 32'h000F_FFFF;
        addrs[5]  = 32'h0010_0000;
        addrs[6]  = 32'h00EF_FFFF;
        addrs[7]  = 32'h00F0_0000;
        addrs[8]  = 32'h00FF_FFFF;
        addrs[9]  = 32'h0100_0000;
        addrs[10] = 32'h0000_0000;
        addrs[11] = 32'hFFFF_FFFF;
        for (int i = 0; i < 12; i++)
          for (int h = 0; h < 4; h++)
            probe(lim, en[0], addrs[i], h[0], h[1]);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule